// File: doc/BRIEF.md
# Burst Corner-Turn Buffer

This block gathers a group of fixed-length bursts from an external memory into an on-chip RAM and then plays them back transposed. A group holds GRID_X*GRID_Y bursts, and each burst is BEATS words long. On playback, the first word of every burst leaves before the second word of any burst. The output therefore runs word-position-major across the whole group. A typical use is pulling co-located samples out of a stack of frames that memory delivers in contiguous bursts.

A sequencer leaves its idle state on a start pulse and then cycles through three phases without end: fill, drain and advance. During fill it issues the burst reads and stores every returned word. During drain it streams the transposed words out under a valid/ready handshake. During advance it moves the external base address forward by GRID_X*GRID_Y+BEATS and clears its counters for the next group. The RAM has one cycle of read latency. Its read register also serves as the output stage, so the stream can run at one word per cycle.

Top module: `burst_transpose_buf`

## Requirements
- R1: While reset is high, `phase` reads 0, `busy` is low, `req_valid` is low and `out_valid` is low.
- R2: From idle, the block moves to the fill phase on the clock edge where `start` is high. It stays idle for as long as `start` stays low.
- R3: In one fill phase the block issues exactly GRID_X*GRID_Y read requests, for bursts b = 0, 1, … in order, at address base + b*BEATS. A request that is not accepted keeps `req_valid` high and `req_addr` unchanged.
- R4: `out_valid` stays low until all GRID_X*GRID_Y*BEATS returned words have been stored. The phase becomes drain on the clock edge that stores the last word.
- R5: Drain delivers word w of burst b as output number w*(GRID_X*GRID_Y)+b. Burst index runs fastest, for w from 0 to BEATS-1.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold on the next cycle. Backpressure never drops or repeats a word.
- R7: After the last output handshake the block spends exactly one cycle in advance and then refills. The first request of the new fill is at the previous base plus GRID_X*GRID_Y+BEATS, and the new group is stored and read back correctly. The base address after reset is 0.
- R8: `phase` encodes idle=0, fill=1, drain=2, advance=3. `busy` is high whenever the phase is not idle.
- R9: `out_valid` is high only during the drain phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Leaves the idle phase |
| req_valid | output | 1 | Burst read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Start address of the requested burst |
| rsp_valid | input | 1 | A returned burst word is present |
| rsp_data | input | DATA_W | Returned burst word |
| out_valid | output | 1 | Transposed word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | DATA_W | Transposed word |
| phase | output | 2 | Current phase (idle, fill, drain, advance) |
| busy | output | 1 | High outside idle |

## Verification
The assertions assume that the memory returns words only for requests it has accepted, in request order, and only during the fill phase. There is one flagged check for that assumption. The bench models the memory with a queue of accepted addresses. It sends a word only from requests accepted in an earlier cycle, and it never sends more words than were requested. Acceptance of requests, gaps between returned words and output backpressure are all randomised, so every stall rule is exercised within these limits.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_DRAIN = 2'd2,
        PH_ADV   = 2'd3
    } phase_e;
endpackage

// File: rtl/tpb_fetch.sv
module tpb_fetch #(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 8,
    parameter int NB     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int CW = $clog2(NB + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } fetch_t;

    fetch_t st_d, st_q;

    always_comb begin
        req_valid = en && (st_q.cnt < CW'(NB));
        req_addr  = base + ADDR_W'(st_q.cnt) * ADDR_W'(BEATS);
        st_d      = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (req_valid && req_ready) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));
endmodule

// File: rtl/tpb_fill_wr.sv
module tpb_fill_wr #(
    parameter int BEATS = 8,
    parameter int NB    = 16,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic          rsp_valid,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          last
);
    localparam int WW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic [WW-1:0] word;
        logic [BW-1:0] burst;
    } wr_t;

    wr_t st_d, st_q;

    always_comb begin
        we    = en && rsp_valid;
        waddr = AW'(st_q.burst) * AW'(BEATS) + AW'(st_q.word);
        last  = we && (st_q.word == WW'(BEATS - 1)) && (st_q.burst == BW'(NB - 1));
        st_d  = st_q;
        if (clr) begin
            st_d = '0;
        end else if (we) begin
            if (st_q.word == WW'(BEATS - 1)) begin
                st_d.word  = '0;
                st_d.burst = (st_q.burst == BW'(NB - 1)) ? '0 : st_q.burst + 1'b1;
            end else begin
                st_d.word = st_q.word + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/tpb_ram.sv
module tpb_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/tpb_drain.sv
module tpb_drain #(
    parameter int BEATS = 8,
    parameter int NB    = 16,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic          out_ready,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic          out_valid,
    output logic          done
);
    localparam int WW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic [BW-1:0] burst;
        logic [WW-1:0] word;
        logic          all_issued;
        logic          vld;
    } dr_t;

    dr_t st_d, st_q;

    always_comb begin
        re        = en && !st_q.all_issued && (!st_q.vld || out_ready);
        raddr     = AW'(st_q.burst) * AW'(BEATS) + AW'(st_q.word);
        out_valid = st_q.vld;
        done      = st_q.all_issued && st_q.vld && out_ready;
        st_d      = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (re) begin
                if (st_q.burst == BW'(NB - 1)) begin
                    st_d.burst = '0;
                    if (st_q.word == WW'(BEATS - 1)) st_d.all_issued = 1'b1;
                    else                             st_d.word = st_q.word + 1'b1;
                end else begin
                    st_d.burst = st_q.burst + 1'b1;
                end
                st_d.vld = 1'b1;
            end else if (out_ready) begin
                st_d.vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/burst_transpose_buf.sv
module burst_transpose_buf #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int BEATS  = 8,
    parameter int GRID_X = 4,
    parameter int GRID_Y = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        phase,
    output logic              busy
);
    import tpb_pkg::*;

    localparam int NB    = GRID_X * GRID_Y;
    localparam int DEPTH = NB * BEATS;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(NB + BEATS);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] base;
    } seq_t;

    seq_t st_d, st_q;

    logic          clr, fill_en, drain_en;
    logic          we, fill_last, re, drain_done;
    logic [AW-1:0] waddr, raddr;

    assign clr      = (st_q.ph == PH_ADV);
    assign fill_en  = (st_q.ph == PH_FILL);
    assign drain_en = (st_q.ph == PH_DRAIN);
    assign phase    = st_q.ph;
    assign busy     = (st_q.ph != PH_IDLE);

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE:  if (start)      st_d.ph = PH_FILL;
            PH_FILL:  if (fill_last)  st_d.ph = PH_DRAIN;
            PH_DRAIN: if (drain_done) st_d.ph = PH_ADV;
            PH_ADV: begin
                st_d.ph   = PH_FILL;
                st_d.base = st_q.base + STEP;
            end
            default:  st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph   <= PH_IDLE;
            st_q.base <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    tpb_fetch #(.ADDR_W(ADDR_W), .BEATS(BEATS), .NB(NB)) u_fetch (
        .clk(clk), .rst(rst), .clr(clr), .en(fill_en), .base(st_q.base),
        .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr)
    );

    tpb_fill_wr #(.BEATS(BEATS), .NB(NB), .AW(AW)) u_wr (
        .clk(clk), .rst(rst), .clr(clr), .en(fill_en), .rsp_valid(rsp_valid),
        .we(we), .waddr(waddr), .last(fill_last)
    );

    tpb_ram #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(rsp_data),
        .re(re), .raddr(raddr), .rdata(out_data)
    );

    tpb_drain #(.BEATS(BEATS), .NB(NB), .AW(AW)) u_drain (
        .clk(clk), .rst(rst), .clr(clr), .en(drain_en), .out_ready(out_ready),
        .re(re), .raddr(raddr), .out_valid(out_valid), .done(drain_done)
    );

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.ph == PH_IDLE && !start |=> st_q.ph == PH_IDLE);

    assert_rsp_in_fill_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> st_q.ph == PH_FILL);

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_adv_base_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.ph == PH_ADV |=> st_q.ph == PH_FILL && req_addr == $past(st_q.base) + STEP);

    assert_out_phase_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> st_q.ph == PH_DRAIN);
endmodule

// File: tb/burst_transpose_buf_tb.sv
module burst_transpose_buf_tb;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 16;
    localparam int BEATS  = 8;
    localparam int GX     = 2;
    localparam int GY     = 3;
    localparam int NB     = GX * GY;
    localparam int TOTAL  = NB * BEATS;
    localparam int STEP   = NB + BEATS;

    logic clk = 1'b0;
    logic rst, start, req_ready, rsp_valid, out_ready;
    logic [DATA_W-1:0] rsp_data;
    logic req_valid, out_valid, busy;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] out_data;
    logic [1:0] phase;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    burst_transpose_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS),
                          .GRID_X(GX), .GRID_Y(GY)) u_dut (
        .clk(clk), .rst(rst), .start(start), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .phase(phase), .busy(busy)
    );

    function automatic logic [DATA_W-1:0] word_of(int a, int w);
        return DATA_W'(a * 37 + w * 11 + 'h1234);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    int exp_ph, base, reqs, words_in, outs, beat, rounds;
    int addr_b [NB];
    int pend [$];
    bit prev_stall;
    logic [DATA_W-1:0] prev_data;

    initial begin
        rst = 1'b1; start = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0;
        rsp_data = '0; out_ready = 1'b0;
        exp_ph = 0; base = 0; reqs = 0; words_in = 0; outs = 0; beat = 0; rounds = 0;
        prev_stall = 0; prev_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(phase == 2'd0, "R1", phase, 0);
        chk(!busy, "R1", busy, 0);
        chk(!req_valid, "R1", req_valid, 0);
        chk(!out_valid, "R1", out_valid, 0);
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(phase == 2'd0, "R2", phase, 0);
        end
        for (int cyc = 0; cyc < 5000 && rounds < 3; cyc++) begin
            bit st, exp_rv, req_hs, out_hs, rv;
            int stall_pct;
            if (cyc > 0) @(negedge clk);
            // compare against model
            chk(phase == 2'(exp_ph), "R8", phase, exp_ph);
            chk(busy == (exp_ph != 0), "R8", busy, exp_ph != 0);
            exp_rv = (exp_ph == 1) && (reqs < NB);
            chk(req_valid == exp_rv, "R3", req_valid, exp_rv);
            if (exp_rv)
                chk(req_addr == ADDR_W'(base + reqs * BEATS), rounds > 0 ? "R7" : "R3",
                    req_addr, base + reqs * BEATS);
            if (exp_ph != 2) chk(!out_valid, "R4", out_valid, 0);
            if (out_valid) begin
                chk(exp_ph == 2, "R9", exp_ph, 2);
                if (outs < TOTAL)
                    chk(out_data == word_of(addr_b[outs % NB], outs / NB), "R5",
                        out_data, word_of(addr_b[outs % NB], outs / NB));
            end
            if (prev_stall) begin
                chk(out_valid, "R6", out_valid, 1);
                chk(out_data == prev_data, "R6", out_data, prev_data);
            end
            // drive stimulus
            stall_pct = (rounds == 0) ? 0 : (rounds == 1 ? 30 : 60);
            st = (cyc == 0);
            start     = st;
            req_ready = ($urandom_range(99) >= stall_pct);
            out_ready = ($urandom_range(99) >= stall_pct);
            rv = (exp_ph == 1) && (pend.size() > 0) && ($urandom_range(99) >= stall_pct / 2);
            rsp_valid = rv;
            rsp_data  = rv ? word_of(pend[0], beat) : '0;
            req_hs = req_valid && req_ready;
            out_hs = out_valid && out_ready;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            // advance model to the next edge
            case (exp_ph)
                0: if (st) exp_ph = 1;
                1: begin
                    if (rv) begin
                        words_in++;
                        beat++;
                        if (beat == BEATS) begin
                            beat = 0;
                            void'(pend.pop_front());
                        end
                        if (words_in == TOTAL) exp_ph = 2;
                    end
                    if (req_hs) begin
                        addr_b[reqs] = int'(req_addr);
                        pend.push_back(int'(req_addr));
                        reqs++;
                    end
                end
                2: if (out_hs) begin
                    outs++;
                    if (outs == TOTAL) exp_ph = 3;
                end
                default: begin
                    base = base + STEP;
                    reqs = 0; words_in = 0; outs = 0;
                    rounds++;
                    exp_ph = 1;
                end
            endcase
        end
        @(negedge clk);
        chk(rounds == 3, "R7", rounds, 3);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 act=%0d exp=%0d", rounds, 3);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule